// File: doc/BRIEF.md
# Retrigger-Aware Timer Prescaler

This block turns the input clock into a count-enable tick for a timer counter. A three-bit select picks one of eight divide ratios: 1, 2, 4, 8, 16, 64, 256 or 1024. The set is deliberately uneven, because 32 and 128 are not offered. It also decides when a retrigger pulse reaches the counter as a reload strobe, and whether the same retrigger restarts the prescaler's own count.

There are three retrigger policies. In the first, the reload strobe follows on the next input clock. In the second, it waits for the next prescaled tick. In the third, it follows on the next input clock and the prescaler count also restarts from zero. The divide select and the policy select are only taken while the block is disabled. The counter that consumes the tick and reload, and the event routing that produces the retrigger, belong to the surrounding timer.

Top module: `retrig_prescaler`

## Requirements
- R1: Select code k (0..7) gives a divide ratio N of 1, 2, 4, 8, 16, 64, 256, 1024 respectively. After enable rises, the first tick comes in the N-th enabled cycle, counting the cycle in which enable first reads 1 as cycle 1.
- R2: With ratio 1, `tick` is high in every cycle in which `enable` is high.
- R3: With any ratio N > 1, `tick` is a single-cycle pulse that repeats every N enabled cycles.
- R4: While `enable` is low, `tick` and `reload` are low, any pending reload is dropped and the prescaler count is held at zero.
- R5: `div_sel` and `sync_mode` are sampled only while `enable` is low. Changing them while `enable` is high has no effect on `tick` or `reload`.
- R6: With `sync_mode` = 0, a `retrig` sampled high at a rising edge while enabled gives `reload` high in the following cycle, and the tick phase is unchanged.
- R7: With `sync_mode` = 1, a `retrig` sampled high in cycle t gives `reload` high in the first cycle after t in which `tick` is high, and in no other cycle.
- R8: With `sync_mode` = 1, further retriggers that arrive while a reload is pending add no extra `reload` pulse.
- R9: With `sync_mode` = 2, a `retrig` in cycle t gives `reload` in cycle t+1, and the prescaler count restarts so that the next tick falls in cycle t+N.
- R10: `sync_mode` = 3 behaves exactly as `sync_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Peripheral enable |
| div_sel | input | 3 | Divide ratio select, codes as in R1 |
| sync_mode | input | 2 | Retrigger policy: 0 next clock, 1 next tick, 2 next clock with prescaler restart, 3 as 0 |
| retrig | input | 1 | Retrigger pulse, sampled on each rising edge |
| tick | output | 1 | Prescaled count-enable tick |
| reload | output | 1 | Counter reload/clear strobe |

## Verification
The hardest case to reach is the tick-wait policy with a retrigger that lands in the same cycle as the tick serving an earlier pending reload. That case needs a long ratio, a burst of retriggers, and one retrigger placed exactly on a tick edge. Directed bursts on divide-by-16 build the merge case. A long random run with mostly-enabled cycles, frequent retriggers and ratio and policy selects that keep changing then hits the tick-edge coincidences and the freeze-while-enabled cases. A bench model updated once per edge predicts every cycle's outputs.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        SYNC_CLK     = 2'd0,
        SYNC_TICK    = 2'd1,
        SYNC_RESTART = 2'd2,
        SYNC_RSVD    = 2'd3
    } sync_mode_e;

    // log2 of the divide ratio: 0,1,2,3,4 then 6,8,10 (32 and 128 skipped)
    function automatic int ratio_shift(input logic [SEL_W-1:0] sel);
        int s;
        s = int'(sel);
        if (s < 5) return s;
        return 2 * s - 4;
    endfunction

endpackage

// File: rtl/pscl_cfg_hold.sv
module pscl_cfg_hold
    import pscl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [SEL_W-1:0]  sel_q_o,
    output sync_mode_e        mode_q_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        sync_mode_e       mode;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.sel  = sel_in;
            st_d.mode = sync_mode_e'(mode_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: '0, mode: SYNC_CLK};
        else        st_q <= st_d;
    end

    assign sel_q_o  = st_q.sel;
    assign mode_q_o = st_q.mode;

    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(st_q.sel) && $stable(st_q.mode)));

endmodule

// File: rtl/pscl_div_core.sv
module pscl_div_core
    import pscl_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);

    localparam int MAX_SHIFT = 10;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t            st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit = CNT_W'((32'd1 << ratio_shift(sel)) - 32'd1);
        wrap  = (st_q.cnt == limit);
        tick  = enable && wrap;
        st_d  = st_q;
        if (!enable)      st_d.cnt = '0;
        else if (restart) st_d.cnt = '0;
        else if (wrap)    st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    initial begin
        assert_cnt_width_R1: assert (CNT_W >= MAX_SHIFT);
    end

    assert_div1_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sel == '0) |-> tick);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> !tick);

    assert_start_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !$past(enable)) |-> (st_q.cnt == '0));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/pscl_retrig_ctl.sv
module pscl_retrig_ctl
    import pscl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  sync_mode_e mode,
    input  logic       retrig,
    input  logic       tick,
    output logic       restart,
    output logic       reload
);

    typedef struct packed {
        logic rel;
        logic pend;
    } ctl_t;

    ctl_t st_d, st_q;
    logic wait_tick;

    always_comb begin
        wait_tick = (mode == SYNC_TICK);
        restart   = enable && retrig && (mode == SYNC_RESTART);
        reload    = enable && (st_q.rel || (st_q.pend && tick));
        st_d      = st_q;
        if (!enable) begin
            st_d.rel  = 1'b0;
            st_d.pend = 1'b0;
        end else if (wait_tick) begin
            st_d.rel  = 1'b0;
            st_d.pend = (st_q.pend && !tick) || retrig;
        end else begin
            st_d.rel  = retrig;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rel: 1'b0, pend: 1'b0};
        else        st_q <= st_d;
    end

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!reload && !tick));

    assert_next_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig && mode == SYNC_CLK) |=> (reload || !enable));

    assert_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && mode == SYNC_TICK) |-> tick);

    assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wait_tick && st_q.pend && !tick) |=> (st_q.pend || !enable));

    assert_restart_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig && mode == SYNC_RESTART) |=> (reload || !enable));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig && mode == SYNC_RSVD) |=> (reload || !enable));

endmodule

// File: rtl/retrig_prescaler.sv
module retrig_prescaler
    import pscl_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [MODE_W-1:0] sync_mode,
    input  logic              retrig,
    output logic              tick,
    output logic              reload
);

    logic [SEL_W-1:0] sel_q;
    sync_mode_e       mode_q;
    logic             restart;

    pscl_cfg_hold u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .sel_in   (div_sel),
        .mode_in  (sync_mode),
        .sel_q_o  (sel_q),
        .mode_q_o (mode_q)
    );

    pscl_div_core #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .sel     (sel_q),
        .restart (restart),
        .tick    (tick)
    );

    pscl_retrig_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode_q),
        .retrig  (retrig),
        .tick    (tick),
        .restart (restart),
        .reload  (reload)
    );

endmodule

// File: tb/retrig_prescaler_test.sv
module retrig_prescaler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] div_sel = '0;
    logic [1:0] sync_mode = '0;
    logic       retrig = 1'b0;
    logic       tick, reload;

    int checks = 0;
    int errors = 0;

    // bench model state
    int m_cnt = 0;
    bit m_pend = 0, m_rel = 0;
    int m_sel = 0, m_mode = 0;
    bit obs_tick, obs_rel;

    always #5 clk = ~clk;

    retrig_prescaler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .sync_mode(sync_mode), .retrig(retrig), .tick(tick), .reload(reload)
    );

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1;    1: return 2;    2: return 4;   3: return 8;
            4: return 16;   5: return 64;   6: return 256; default: return 1024;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, check outputs, advance model at posedge
    task automatic step(input bit en, input int sel, input int mode, input bit rt);
        bit e_tick, e_rel;
        int eff;
        string tt, rtag;
        @(negedge clk);
        enable = en; div_sel = 3'(sel); sync_mode = 2'(mode); retrig = rt;
        #1;
        e_tick = en && (m_cnt == ratio_of(m_sel) - 1);
        e_rel  = en && (m_rel || (m_pend && e_tick));
        tt   = !en ? "R4" : (m_sel == 0 ? "R2" : "R3");
        rtag = !en ? "R4" : (m_mode == 1 ? "R7" : (m_mode == 2 ? "R9" :
               (m_mode == 3 ? "R10" : "R6")));
        obs_tick = tick; obs_rel = reload;
        check(tt, int'(tick), int'(e_tick));
        check(rtag, int'(reload), int'(e_rel));
        @(posedge clk);
        if (!en) begin
            m_cnt = 0; m_pend = 0; m_rel = 0; m_sel = sel; m_mode = mode;
        end else begin
            eff = (m_mode == 3) ? 0 : m_mode;
            if (eff == 1) begin
                m_rel = 0; m_pend = (m_pend && !e_tick) || rt;
            end else begin
                m_rel = rt; m_pend = 0;
            end
            if (rt && eff == 2) m_cnt = 0;
            else if (e_tick)    m_cnt = 0;
            else                m_cnt = m_cnt + 1;
        end
    endtask

    initial begin
        #(20_000_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, cnt_t, cnt_r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset tick", int'(tick), 0);
        check("R4 reset reload", int'(reload), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: first tick lands in the N-th enabled cycle for every code
        for (int k = 0; k < 8; k++) begin
            step(0, k, 0, 0);
            step(0, k, 0, 0);
            n = 0;
            do begin
                step(1, k, 0, 0);
                n++;
            end while (!obs_tick && n < 2000);
            check("R1 first tick position", n, ratio_of(k));
            n = 0;
            do begin
                step(1, k, 0, 0);
                n++;
            end while (!obs_tick && n < 2000);
            check("R3 tick period", n, ratio_of(k));
        end

        // R5: select changes while enabled are ignored (div2 stays div2)
        step(0, 1, 0, 0);
        cnt_t = 0;
        for (int i = 0; i < 20; i++) begin
            step(1, 7 - (i % 3), 3, 0);
            cnt_t += int'(obs_tick);
        end
        check("R5 ticks in 20 cycles", cnt_t, 10);

        // R8: burst of retriggers on div16, tick-wait policy
        step(0, 4, 1, 0);
        cnt_r = 0;
        for (int i = 0; i < 16; i++) begin
            step(1, 4, 1, i < 4);
            cnt_r += int'(obs_rel);
        end
        check("R8 merged reload count", cnt_r, 1);

        // R9: restart policy on div8, next tick 8 cycles after retrig
        step(0, 3, 2, 0);
        for (int i = 0; i < 5; i++) step(1, 3, 2, 0);
        step(1, 3, 2, 1);
        step(1, 3, 2, 0);
        check("R9 reload after restart", int'(obs_rel), 1);
        n = 1;
        while (!obs_tick && n < 20) begin
            step(1, 3, 2, 0);
            n++;
        end
        check("R9 tick distance", n, 8);

        // R6 / R10: tick phase unaffected in next-clock policies
        for (int md = 0; md < 4; md += 3) begin
            step(0, 2, md, 0);
            step(1, 2, md, 0);
            step(1, 2, md, 1);
            step(1, 2, md, 0);
            check(md == 0 ? "R6 reload" : "R10 reload", int'(obs_rel), 1);
            step(1, 2, md, 0);
            check(md == 0 ? "R6 phase kept" : "R10 phase kept", int'(obs_tick), 1);
        end

        // random run
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 100) < 93, $urandom % 5, $urandom % 4,
                 ($urandom % 100) < 20);
        end
        step(0, 0, 0, 1);
        check("R4 disabled reload", int'(obs_rel), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule